// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block turns a 16-bit up counter and two compare values into a periodic, pulse-width-modulated output. A period register sets the count at which the counter wraps back to zero. A duty register sets a second count inside that period. An output flip-flop inverts on either match, and each of the two inversions can be enabled on its own. Each time the period match clears the counter, the block also raises a one-cycle interrupt pulse.

The counter advances only on the selected count source. That source is either a rising edge of an external input or one of three prescaled single-cycle enables, which come from outside the block. The duty value can be double-buffered, so that a new duty value written in the middle of a period only takes effect at the next wrap. Software uses the interrupt as the safe moment to load new values.

Top module: `ppg_timer`

## Requirements
- R1: After reset, pulse_out and period_irq are 0. The counter, the duty value, the period value and all control bits are 0.
- R2: While run is 1, the counter goes up by one on each selected tick. On a tick where the counter equals the period value, the counter goes back to 0 instead. This gives a period of (period value + 1) ticks.
- R3: Control bits [1:0] choose the count source: 0 = a rising edge of ext_in (ext_in is 1 in this cycle and was 0 in the previous cycle), 1 = tick_div1, 2 = tick_div4, 3 = tick_div16. The sources that are not chosen have no effect on the count.
- R4: When control bit 2 is 1, pulse_out inverts one cycle after a tick on which the counter equals the duty value.
- R5: When control bit 3 is 1, pulse_out inverts one cycle after a tick on which the counter equals the period value.
- R6: When a duty match and a period match fall on the same tick and either inversion is enabled, pulse_out inverts exactly once.
- R7: A control write (wr_sel = 0) with wr_data bit 5 set drives pulse_out to 0 on the next cycle. This write wins over an inversion on the same edge. Bit 5 is not stored.
- R8: Writes use wr_sel 1 for duty and wr_sel 2 for period, and wr_sel 3 is ignored. With control bit 4 at 0, a duty write takes effect at once. With control bit 4 at 1, a duty write goes to a buffer, and the buffer is copied into the active duty value only on a period-match tick.
- R9: period_irq is high for exactly one cycle after each period-match tick. It is high in the same cycle in which the counter reads 0 after the wrap.
- R10: While run is 0, the counter is held at 0, no match occurs and pulse_out holds its value. When run returns to 1, counting starts again from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 duty, 2 period |
| wr_data | input | 16 | Write data |
| run | input | 1 | Count enable; low clears the counter |
| ext_in | input | 1 | External count input, counted on its rising edge |
| tick_div1 | input | 1 | Prescaled enable, ratio 1 |
| tick_div4 | input | 1 | Prescaled enable, ratio 4 |
| tick_div16 | input | 1 | Prescaled enable, ratio 16 |
| period_irq | output | 1 | One-cycle pulse on each period wrap |
| pulse_out | output | 1 | Pulse output from the toggle flip-flop |

## Verification
Every result is due exactly one clock edge after the tick or write that causes it. The counter, the flip-flop, the interrupt and the active duty value are all single registers fed from the same edge. The bench therefore drives one cycle's inputs on the falling edge and lets a single rising edge pass. It then compares pulse_out and period_irq on the next falling edge against counts it derives from the tick pattern it drove itself. Duty writes in buffered mode are placed away from the wrap tick, so that the copy and the new write are easy to tell apart.

// File: rtl/ppg_timer.sv
module ppg_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         run,
  input  logic         ext_in,
  input  logic         tick_div1,
  input  logic         tick_div4,
  input  logic         tick_div16,
  output logic         period_irq,
  output logic         pulse_out
);
  localparam int CW = 5;
  localparam int B_DUTY_EN = 2;
  localparam int B_CYC_EN  = 3;
  localparam int B_DBUF    = 4;
  localparam int B_FORCE   = 5;

  logic [CW-1:0] ctrl_q;
  logic [W-1:0]  cnt_q, duty_q, dbuf_q, cyc_q;
  logic          tff_q, irq_q, ext_q, tick;

  always_comb begin
    case (ctrl_q[1:0])
      2'd0:    tick = ext_in & ~ext_q;
      2'd1:    tick = tick_div1;
      2'd2:    tick = tick_div4;
      default: tick = tick_div16;
    endcase
  end

  wire step      = run & tick;
  wire duty_hit  = step & (cnt_q == duty_q);
  wire cyc_hit   = step & (cnt_q == cyc_q);
  wire flip      = (ctrl_q[B_DUTY_EN] & duty_hit) | (ctrl_q[B_CYC_EN] & cyc_hit);
  wire wr_ctrl   = wr_en & (wr_sel == 2'd0);
  wire wr_duty   = wr_en & (wr_sel == 2'd1);
  wire wr_cyc    = wr_en & (wr_sel == 2'd2);
  wire force_low = wr_ctrl & wr_data[B_FORCE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      duty_q <= '0;
      dbuf_q <= '0;
      cyc_q  <= '0;
      tff_q  <= 1'b0;
      irq_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      ext_q <= ext_in;
      irq_q <= cyc_hit;
      if (!run)         cnt_q <= '0;
      else if (cyc_hit) cnt_q <= '0;
      else if (step)    cnt_q <= cnt_q + 1'b1;
      if (force_low)    tff_q <= 1'b0;
      else if (flip)    tff_q <= ~tff_q;
      if (wr_ctrl)      ctrl_q <= wr_data[CW-1:0];
      if (wr_cyc)       cyc_q <= wr_data;
      if (wr_duty)      dbuf_q <= wr_data;
      if (wr_duty && !ctrl_q[B_DBUF])      duty_q <= wr_data;
      else if (cyc_hit && ctrl_q[B_DBUF])  duty_q <= dbuf_q;
    end
  end

  assign period_irq = irq_q;
  assign pulse_out  = tff_q;

  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cnt_q == '0)); // R9
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0) && !irq_q); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q)); // R2
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !force_low) |=> $stable(tff_q)); // R10
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |=> !tff_q); // R7
  AST_DUTY_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_DBUF] && !cyc_hit) |=> $stable(duty_q)); // R8
endmodule

// File: tb/ppg_timer_bench.sv
`timescale 1ns/1ps
module ppg_timer_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, run = 0, ext_in = 0;
  logic tick_div1 = 0, tick_div4 = 0, tick_div16 = 0;
  logic [1:0] wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic period_irq, pulse_out;

  always #2 clk = ~clk;

  ppg_timer u_ppg_timer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .run(run), .ext_in(ext_in), .tick_div1(tick_div1),
    .tick_div4(tick_div4), .tick_div16(tick_div16), .period_irq(period_irq),
    .pulse_out(pulse_out));

  int checks = 0, fails = 0, gc = 0;
  bit done = 0;
  string tag = "R1";
  logic [4:0] m_ctrl = 0;
  logic [15:0] m_cnt = 0, m_duty = 0, m_buf = 0, m_cyc = 0;
  logic m_tff = 0, m_irq = 0, m_extq = 0;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, gc, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic w, input logic [1:0] a, input logic [15:0] d);
    logic tk, dm, cm, tog, e1, e4, e16, ex;
    e1 = 1'b1; e4 = (gc % 4 == 0); e16 = (gc % 16 == 0); ex = ((gc / 3) % 2) == 1;
    tick_div1 = e1; tick_div4 = e4; tick_div16 = e16; ext_in = ex;
    run = r; wr_en = w; wr_sel = a; wr_data = d;
    @(posedge clk);
    case (m_ctrl[1:0])
      2'd0: tk = ex & ~m_extq;
      2'd1: tk = e1;
      2'd2: tk = e4;
      default: tk = e16;
    endcase
    tog = 0;
    if (!r) begin m_cnt = 0; m_irq = 0; end
    else if (tk) begin
      dm = (m_cnt == m_duty); cm = (m_cnt == m_cyc);
      tog = (m_ctrl[2] && dm) || (m_ctrl[3] && cm);
      m_irq = cm;
      m_cnt = cm ? 16'd0 : m_cnt + 16'd1;
      if (cm && m_ctrl[4]) m_duty = m_buf;
    end else m_irq = 0;
    if (w && a == 2'd0 && d[5]) m_tff = 0;
    else if (tog) m_tff = ~m_tff;
    if (w && a == 2'd1) begin m_buf = d; if (!m_ctrl[4]) m_duty = d; end
    if (w && a == 2'd2) m_cyc = d;
    if (w && a == 2'd0) m_ctrl = d[4:0];
    m_extq = ex;
    gc++;
    @(negedge clk);
    wr_en = 0;
    chk(tag, pulse_out, m_tff);
    chk("R9", period_irq, m_irq);
  endtask

  task automatic setup(input logic [15:0] ctrl, input logic [15:0] duty, input logic [15:0] per);
    cyc(0, 1, 2'd0, ctrl | 16'h20);
    cyc(0, 1, 2'd1, duty);
    cyc(0, 1, 2'd2, per);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    chk("R1", pulse_out, 1'b0);
    chk("R1", period_irq, 1'b0);
    cyc(1, 0, 2'd0, 16'd0);

    for (int p = 0; p <= 5; p++)
      for (int dv = 0; dv <= 6; dv++)
        for (int en = 0; en < 4; en++) begin
          tag = (dv == p) ? "R6" : ((en == 2) ? "R5" : "R4");
          setup(16'(1 | (en << 2)), 16'(dv), 16'(p));
          for (int k = 0; k < 2 * (p + 1) + 3; k++) cyc(1, 0, 2'd0, 16'd0);
          tag = "R2";
        end

    for (int s = 0; s < 4; s++) begin
      tag = "R3";
      setup(16'(s | 12), 16'd1, 16'd2);
      for (int k = 0; k < 60; k++) cyc(1, 0, 2'd0, 16'd0);
    end

    tag = "R8";
    setup(16'h1D, 16'd2, 16'd7);
    for (int k = 0; k < 4; k++) cyc(1, 0, 2'd0, 16'd0);
    cyc(1, 1, 2'd1, 16'd5);
    for (int k = 0; k < 20; k++) cyc(1, 0, 2'd0, 16'd0);
    cyc(1, 1, 2'd3, 16'd1);
    for (int k = 0; k < 10; k++) cyc(1, 0, 2'd0, 16'd0);
    setup(16'h0D, 16'd2, 16'd7);
    for (int k = 0; k < 4; k++) cyc(1, 0, 2'd0, 16'd0);
    cyc(1, 1, 2'd1, 16'd6);
    for (int k = 0; k < 20; k++) cyc(1, 0, 2'd0, 16'd0);

    tag = "R10";
    setup(16'h0D, 16'd3, 16'd9);
    for (int k = 0; k < 5; k++) cyc(1, 0, 2'd0, 16'd0);
    for (int k = 0; k < 8; k++) cyc(0, 0, 2'd0, 16'd0);
    for (int k = 0; k < 25; k++) cyc(1, 0, 2'd0, 16'd0);

    tag = "R7";
    setup(16'h0D, 16'd1, 16'd5);
    for (int k = 0; k < 2; k++) cyc(1, 0, 2'd0, 16'd0);
    cyc(1, 1, 2'd0, 16'h2D);
    for (int k = 0; k < 12; k++) cyc(1, 0, 2'd0, 16'd0);
    cyc(1, 1, 2'd0, 16'h2D);
    for (int k = 0; k < 12; k++) cyc(1, 0, 2'd0, 16'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule